// File: doc/BRIEF.md
# Series Cell Pack Protection Controller

This block is the digital decision core of a protector for a pack of three or four cells in series. Analog comparators outside the block reduce every cell voltage, the discharge current and the load-monitor node to single-bit flags. The block debounces those flags with delay counters and picks one of five protection states. From that state it drives the charge-FET and discharge-FET shut-off requests, the enables for the on-chip regulator and the cell monitor amplifier, and the pull-up and pull-down requests for the load-monitor node.

Each fault has its own debounce counter, and each fault has its own exit condition. A fault is taken only when its flag stays asserted for the full delay in consecutive clock cycles. The three discharge-current tiers count side by side, so a heavy short trips on the shortest delay. Every pin is a plain level signal with no handshake. The flags are sampled on each rising clock edge. The outputs are decoded from the state register, so an output responds one cycle after the edge that changes the state.

Top module: `batt_guard_ctrl`

## Requirements
- R1: A synchronous reset, held high for one edge or more, puts the block in the normal state. Both FETs are on (`chg_off`=0, `dis_off`=0), `reg_en`=1 and `amp_en`=1, and both node pulls are off.
- R2: In the normal state, if any bit of `cell_hi` is high on OVCH_DLY consecutive rising edges, the block enters overcharge at the last of those edges. In overcharge only `chg_off` is 1, and the other outputs keep their normal values.
- R3: Each delay counter restarts from zero when its flag is low on any edge. A flag that drops even once before its delay completes causes no trip.
- R4: Overcharge returns to normal on the first edge where every bit of `cell_rel` is high, or where `cur_lvl[0]` is high. While neither holds, the block stays in overcharge.
- R5: In the normal or overcharge state, if any bit of `cell_lo` is high on ODIS_DLY consecutive edges, the block enters overdischarge. There `dis_off`=1, `chg_off`=0, and the regulator and amplifier stay on. On the next edge with `chg_det` low, it moves to power-down. In power-down `chg_off`=1, `dis_off`=1, `reg_en`=0, `amp_en`=0 and `node_pd`=1.
- R6: Power-down is left only on an edge with `chg_det` high, and the block then goes to the overdischarge state. No other input has any effect in power-down.
- R7: Overdischarge returns to normal only on an edge where no bit of `cell_lo` is set and `node_half` is high.
- R8: Each bit of `cur_lvl` (bit 0 = lowest current, bit 2 = highest) has its own counter. The delays are OC1_DLY, OC2_DLY and OC3_DLY, and they run in parallel in the normal and overcharge states. Any tier that completes its delay moves the block to overcurrent. In overcurrent `chg_off`=1, `dis_off`=1 and `node_pu`=1, with the regulator and amplifier on.
- R9: Overcurrent is left, to the normal state, only on an edge with `load_gone` high.
- R10: When trips complete on the same edge, overcurrent wins over overdischarge, and overdischarge wins over overcharge.
- R11: `node_pu` and `node_pd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cell_hi | input | NCELL | Per cell: above overcharge threshold |
| cell_rel | input | NCELL | Per cell: below overcharge release threshold |
| cell_lo | input | NCELL | Per cell: below overdischarge threshold |
| cur_lvl | input | 3 | Discharge current above tier 1/2/3 (bit 0 lowest) |
| chg_det | input | 1 | Charger connected (load node above the top tier) |
| node_half | input | 1 | Load node at or above half the supply |
| load_gone | input | 1 | Load removed after an overcurrent |
| chg_off | output | 1 | Charge FET off (high-impedance request) |
| dis_off | output | 1 | Discharge FET off |
| reg_en | output | 1 | Regulator enable |
| amp_en | output | 1 | Monitor amplifier enable |
| node_pu | output | 1 | Load-node pull-up request |
| node_pd | output | 1 | Load-node pull-down request |

## Verification
All six outputs are a pure decode of the state register, so any wrong state shows at the ports in the cycle after the edge that caused it. A counter that is off by one moves a trip by one cycle, and the bench catches that because it compares against a cycle-exact model on every clock. A counter that misses a restart trips when it should hold, and a release taken at the wrong time leaves a FET on or off in the wrong cycle. The same-edge priority cases and the power-down wake-up path produce output patterns that no other state produces, so a misrouted transition cannot stay hidden.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_OVCH  = 3'd1,
    ST_ODIS  = 3'd2,
    ST_PDN   = 3'd3,
    ST_OVCUR = 3'd4
  } gstate_t;

  localparam int NUM_TIERS = 3;

  typedef struct packed {
    logic chg_off;
    logic dis_off;
    logic reg_en;
    logic amp_en;
    logic node_pu;
    logic node_pd;
  } gouts_t;

endpackage

// File: rtl/batt_guard_dly.sv
module batt_guard_dly #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic trip
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;

  // cnt holds how many earlier consecutive edges saw cond high, saturating at LAST
  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign trip = cond && (cnt == LAST);

  generate
    if (DLY > 1) begin : g_chk
      AST_TRIP_CONT: assert property (@(posedge clk) disable iff (rst)
        trip |-> $past(cond)); // R3
    end
  endgenerate

endmodule

// File: rtl/batt_guard_fsm.sv
module batt_guard_fsm
  import batt_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TIERS-1:0] oc_trip,
  input  logic                 od_trip,
  input  logic                 ov_trip,
  input  logic                 all_rel,
  input  logic                 any_lo,
  input  logic                 cur_low,
  input  logic                 chg_det,
  input  logic                 node_half,
  input  logic                 load_gone,
  output gstate_t              st
);
  gstate_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_NORM: begin
        if (|oc_trip)     st_nx = ST_OVCUR;
        else if (od_trip) st_nx = ST_ODIS;
        else if (ov_trip) st_nx = ST_OVCH;
      end
      ST_OVCH: begin
        if (|oc_trip)               st_nx = ST_OVCUR;
        else if (od_trip)           st_nx = ST_ODIS;
        else if (all_rel || cur_low) st_nx = ST_NORM;
      end
      ST_ODIS: begin
        if (!any_lo && node_half) st_nx = ST_NORM;
        else if (!chg_det)        st_nx = ST_PDN;
      end
      ST_PDN: begin
        if (chg_det) st_nx = ST_ODIS;
      end
      ST_OVCUR: begin
        if (load_gone) st_nx = ST_NORM;
      end
      default: st_nx = ST_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_NORM;
    else     st <= st_nx;
  end

  AST_PDN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PDN && !chg_det) |=> (st == ST_PDN)); // R6
  AST_OC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OVCUR && !load_gone) |=> (st == ST_OVCUR)); // R9
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ODIS && any_lo) |=> (st != ST_NORM)); // R7
  AST_OC_FIRST: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_NORM || st == ST_OVCH) && (|oc_trip)) |=> (st == ST_OVCUR)); // R10

endmodule

// File: rtl/batt_guard_outdec.sv
module batt_guard_outdec
  import batt_guard_pkg::*;
(
  input  gstate_t st,
  output gouts_t  o
);
  always_comb begin
    o = '{chg_off: 1'b0, dis_off: 1'b0, reg_en: 1'b1, amp_en: 1'b1,
          node_pu: 1'b0, node_pd: 1'b0};
    unique case (st)
      ST_NORM: ;
      ST_OVCH: o.chg_off = 1'b1;
      ST_ODIS: o.dis_off = 1'b1;
      ST_PDN: begin
        o.chg_off = 1'b1;
        o.dis_off = 1'b1;
        o.reg_en  = 1'b0;
        o.amp_en  = 1'b0;
        o.node_pd = 1'b1;
      end
      ST_OVCUR: begin
        o.chg_off = 1'b1;
        o.dis_off = 1'b1;
        o.node_pu = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/batt_guard_ctrl.sv
module batt_guard_ctrl
  import batt_guard_pkg::*;
#(
  parameter int NCELL    = 4,
  parameter int OVCH_DLY = 40,
  parameter int ODIS_DLY = 30,
  parameter int OC1_DLY  = 20,
  parameter int OC2_DLY  = 10,
  parameter int OC3_DLY  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] cell_hi,
  input  logic [NCELL-1:0] cell_rel,
  input  logic [NCELL-1:0] cell_lo,
  input  logic [2:0]       cur_lvl,
  input  logic             chg_det,
  input  logic             node_half,
  input  logic             load_gone,
  output logic             chg_off,
  output logic             dis_off,
  output logic             reg_en,
  output logic             amp_en,
  output logic             node_pu,
  output logic             node_pd
);
  localparam int OC_D [NUM_TIERS] = '{OC1_DLY, OC2_DLY, OC3_DLY};

  gstate_t              st;
  gouts_t               outs;
  logic                 any_hi, any_lo, all_rel, watching;
  logic [NUM_TIERS-1:0] oc_trip;
  logic                 od_trip, ov_trip;

  assign any_hi   = |cell_hi;
  assign any_lo   = |cell_lo;
  assign all_rel  = &cell_rel;
  assign watching = (st == ST_NORM) || (st == ST_OVCH);

  genvar g;
  generate
    for (g = 0; g < NUM_TIERS; g++) begin : g_tier
      batt_guard_dly #(.DLY(OC_D[g])) u_oc (
        .clk (clk),
        .rst (rst),
        .cond(cur_lvl[g] && watching),
        .trip(oc_trip[g])
      );
    end
  endgenerate

  batt_guard_dly #(.DLY(ODIS_DLY)) u_od (
    .clk (clk),
    .rst (rst),
    .cond(any_lo && watching),
    .trip(od_trip)
  );

  batt_guard_dly #(.DLY(OVCH_DLY)) u_ov (
    .clk (clk),
    .rst (rst),
    .cond(any_hi && (st == ST_NORM)),
    .trip(ov_trip)
  );

  batt_guard_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .oc_trip  (oc_trip),
    .od_trip  (od_trip),
    .ov_trip  (ov_trip),
    .all_rel  (all_rel),
    .any_lo   (any_lo),
    .cur_low  (cur_lvl[0]),
    .chg_det  (chg_det),
    .node_half(node_half),
    .load_gone(load_gone),
    .st       (st)
  );

  batt_guard_outdec u_dec (
    .st(st),
    .o (outs)
  );

  assign chg_off = outs.chg_off;
  assign dis_off = outs.dis_off;
  assign reg_en  = outs.reg_en;
  assign amp_en  = outs.amp_en;
  assign node_pu = outs.node_pu;
  assign node_pd = outs.node_pd;

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(node_pu && node_pd)); // R11
  AST_PDN_OUTS: assert property (@(posedge clk) disable iff (rst)
    node_pd |-> (chg_off && dis_off && !reg_en && !amp_en)); // R5
  AST_RESET_NORM: assert property (@(posedge clk)
    rst |=> (!chg_off && !dis_off && reg_en && amp_en)); // R1

endmodule

// File: tb/batt_guard_ctrl_test.sv
module batt_guard_ctrl_test;
  localparam int NC = 4;
  localparam int OV_D = 40, OD_D = 30, C1 = 20, C2 = 10, C3 = 4;
  localparam logic [5:0] V_NORM = 6'b001100, V_OVCH = 6'b101100,
                         V_ODIS = 6'b011100, V_PDN  = 6'b110001,
                         V_OC   = 6'b111110;

  logic clk = 1'b0, rst = 1'b1;
  logic [NC-1:0] cell_hi = '0, cell_rel = '1, cell_lo = '0;
  logic [2:0] cur_lvl = '0;
  logic chg_det = 1'b0, node_half = 1'b0, load_gone = 1'b0;
  logic chg_off, dis_off, reg_en, amp_en, node_pu, node_pd;

  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  batt_guard_ctrl #(.NCELL(NC), .OVCH_DLY(OV_D), .ODIS_DLY(OD_D),
    .OC1_DLY(C1), .OC2_DLY(C2), .OC3_DLY(C3)) uut (
    .clk(clk), .rst(rst), .cell_hi(cell_hi), .cell_rel(cell_rel),
    .cell_lo(cell_lo), .cur_lvl(cur_lvl), .chg_det(chg_det),
    .node_half(node_half), .load_gone(load_gone), .chg_off(chg_off),
    .dis_off(dis_off), .reg_en(reg_en), .amp_en(amp_en),
    .node_pu(node_pu), .node_pd(node_pd));

  // behavioural reference: 0 normal, 1 overcharge, 2 overdischarge, 3 power-down, 4 overcurrent
  int m_st = 0, r_ov = 0, r_od = 0;
  int r_oc [3] = '{0, 0, 0};
  int dly_oc [3] = '{C1, C2, C3};

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; r_ov = 0; r_od = 0; r_oc = '{0, 0, 0};
    end else begin
      bit watch, oc_hit, od_hit, ov_hit;
      watch = (m_st == 0 || m_st == 1);
      oc_hit = 1'b0;
      for (int i = 0; i < 3; i++) begin
        r_oc[i] = (watch && cur_lvl[i]) ? r_oc[i] + 1 : 0;
        if (r_oc[i] >= dly_oc[i]) oc_hit = 1'b1;
      end
      r_od = (watch && |cell_lo) ? r_od + 1 : 0;
      od_hit = r_od >= OD_D;
      r_ov = (m_st == 0 && |cell_hi) ? r_ov + 1 : 0;
      ov_hit = r_ov >= OV_D;
      case (m_st)
        0: if (oc_hit) m_st = 4; else if (od_hit) m_st = 2; else if (ov_hit) m_st = 1;
        1: if (oc_hit) m_st = 4; else if (od_hit) m_st = 2;
           else if (&cell_rel || cur_lvl[0]) m_st = 0;
        2: if (!(|cell_lo) && node_half) m_st = 0; else if (!chg_det) m_st = 3;
        3: if (chg_det) m_st = 2;
        default: if (load_gone) m_st = 0;
      endcase
    end
  end

  function automatic logic [5:0] model_out(int s);
    case (s)
      1: return V_OVCH;
      2: return V_ODIS;
      3: return V_PDN;
      4: return V_OC;
      default: return V_NORM;
    endcase
  endfunction

  function automatic logic [5:0] dut_out();
    return {chg_off, dis_off, reg_en, amp_en, node_pu, node_pd};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, plus the pull exclusivity (R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, dut_out(), model_out(m_st));
      total++;
      if (node_pu && node_pd) begin
        bad++;
        $display("FAIL R11: pulls actual=11 expected=not both at %0t", $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1", dut_out(), V_NORM);

    // R3 then R2: interrupted overcharge, then a full run
    tag = "R3";
    cell_hi[2] = 1'b1; cell_rel[2] = 1'b0;
    step(OV_D - 1);
    cell_hi[2] = 1'b0;
    step(1);
    chk("R3", dut_out(), V_NORM);
    tag = "R2";
    cell_hi[2] = 1'b1;
    step(OV_D - 1);
    chk("R2", dut_out(), V_NORM);
    step(1);
    chk("R2", dut_out(), V_OVCH);

    // R4: hold until all cells below release, then release by load current
    tag = "R4";
    cell_hi[2] = 1'b0;
    step(5);
    chk("R4", dut_out(), V_OVCH);
    cell_rel = '1;
    step(1);
    chk("R4", dut_out(), V_NORM);
    cell_hi[1] = 1'b1; cell_rel[1] = 1'b0;
    step(OV_D);
    chk("R4", dut_out(), V_OVCH);
    cell_hi[1] = 1'b0;
    cur_lvl = 3'b001;
    step(1);
    cur_lvl = 3'b000;
    chk("R4", dut_out(), V_NORM);
    cell_rel = '1;
    step(2);

    // R8: all tiers at once, shortest delay wins
    tag = "R8";
    cur_lvl = 3'b111;
    step(C3 - 1);
    chk("R8", dut_out(), V_NORM);
    step(1);
    chk("R8", dut_out(), V_OC);
    cur_lvl = 3'b000;
    // R9: only load_gone releases
    tag = "R9";
    chg_det = 1'b1; node_half = 1'b1;
    step(8);
    chk("R9", dut_out(), V_OC);
    chg_det = 1'b0; node_half = 1'b0;
    load_gone = 1'b1;
    step(1);
    load_gone = 1'b0;
    chk("R9", dut_out(), V_NORM);
    tag = "R8";
    cur_lvl = 3'b001;
    step(C1 - 1);
    chk("R8", dut_out(), V_NORM);
    step(1);
    chk("R8", dut_out(), V_OC);
    cur_lvl = 3'b000; load_gone = 1'b1;
    step(1);
    load_gone = 1'b0;

    // R5: overdischarge then power-down
    tag = "R5";
    cell_lo[3] = 1'b1;
    step(OD_D - 1);
    chk("R5", dut_out(), V_NORM);
    step(1);
    chk("R5", dut_out(), V_ODIS);
    step(1);
    chk("R5", dut_out(), V_PDN);

    // R6: power-down ignores everything but the charger flag
    tag = "R6";
    node_half = 1'b1; load_gone = 1'b1; cur_lvl = 3'b111; cell_lo = '0;
    step(10);
    chk("R6", dut_out(), V_PDN);
    cur_lvl = 3'b000; load_gone = 1'b0; node_half = 1'b0; cell_lo[3] = 1'b1;
    chg_det = 1'b1;
    step(1);
    chk("R6", dut_out(), V_ODIS);

    // R7: release needs cells clear and half-supply
    tag = "R7";
    node_half = 1'b1;
    step(5);
    chk("R7", dut_out(), V_ODIS);
    cell_lo = '0; node_half = 1'b0;
    step(3);
    chk("R7", dut_out(), V_ODIS);
    node_half = 1'b1;
    step(1);
    chk("R7", dut_out(), V_NORM);
    chg_det = 1'b0; node_half = 1'b0;
    step(2);

    // R10: overcurrent beats overdischarge on the same edge
    tag = "R10";
    cell_lo[0] = 1'b1;
    step(OD_D - C3);
    cur_lvl = 3'b100;
    step(C3);
    chk("R10", dut_out(), V_OC);
    cell_lo = '0; cur_lvl = 3'b000; load_gone = 1'b1;
    step(1);
    load_gone = 1'b0;
    chk("R10", dut_out(), V_NORM);
    // overdischarge beats overcharge on the same edge
    cell_hi[1] = 1'b1; cell_rel[1] = 1'b0;
    step(OV_D - OD_D);
    cell_lo[0] = 1'b1;
    step(OD_D);
    chk("R10", dut_out(), V_ODIS);
    step(1);
    chk("R10", dut_out(), V_PDN);
    cell_hi = '0; cell_rel = '1; cell_lo = '0;
    chg_det = 1'b1;
    step(1);
    node_half = 1'b1;
    step(1);
    chk("R10", dut_out(), V_NORM);
    chg_det = 1'b0; node_half = 1'b0;
    step(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule